// File: doc/BRIEF.md
# Sixteen-pin GPIO port with two masked interrupt lines

This block is a general-purpose port of sixteen bidirectional pins behind a register interface with 16-bit registers. A data register drives the pins. It has three write-one companions that clear, set or invert chosen bits without a read-modify-write. A direction register selects which pins are driven. When a data or direction write actually changes the value driven on an output pin, that pin gets a one-cycle change strobe.

Each pin is synchronised and then judged by its own configuration: level or edge, active polarity, both-edges and input enable. The result is a per-pin interrupt-state vector. Two independent mask registers, each with clear, set and toggle companions, select which state bits reach interrupt line A and which reach line B. Level-mode pins hold their state bit while they are active and drop it when they are not. Edge-mode pins produce a single-cycle pulse.

The bus handshake is a one-cycle request. The fault code and the read data are valid in the request cycle, and writes take effect at the clock edge that ends that cycle.

Top module: `pio_port16`

## Requirements
- R1: After a synchronous active-low reset every register is zero, so pin_out, pin_oe, out_chg, irq_a and irq_b are all zero.
- R2: Register index is bus_addr[7:2], and a register sits at byte offset four times its index. The indices are: 0 data, 1 data clear, 2 data set, 3 data toggle, 4 mask A, 5 to 7 its clear/set/toggle, 8 mask B, 9 to 11 its clear/set/toggle, 12 direction, 13 polarity, 14 edge select, 15 both-edges, 16 input enable. A legal read returns that register in the request cycle.
- R3: A write to a clear, set or toggle index clears, sets or inverts each base-register bit that has a 1 in the write data. A read of one of these indices returns its base register.
- R4: Only bus_size code 1 (16-bit) is legal. Any other size gives bus_fault 1 whatever the address, with read data 0 and no register change.
- R5: A 16-bit access with bus_addr[1:0] not zero, or with an index above 16, gives bus_fault 2, with read data 0 and no register change. A legal access gives bus_fault 0.
- R6: pin_out equals the data register and pin_oe equals the direction register.
- R7: In the cycle after a write to data, any of its companions or direction, out_chg[i] is 1 exactly when pin i is an output after the write and its data bit changed. At all other times out_chg is 0.
- R8: irq_a is the OR of the interrupt state ANDed with mask A, and irq_b is the same with mask B. A mask write changes the line from the next cycle.
- R9: In level mode (edge bit 0) with input enabled, a pin's state bit is pin XOR polarity (polarity 0 means active high). A pin change reaches the state on the third rising edge that samples it.
- R10: In edge mode (edge bit 1, both-edges 0) with input enabled, a rising input (polarity 0) or a falling input (polarity 1) sets the state bit for exactly one cycle, with the same latency as R9.
- R11: In edge mode with the both-edges bit set, either transition produces the one-cycle pulse, regardless of polarity.
- R12: A pin with input enable 0 never raises state. Its level-mode state bit keeps its value, and its edge-mode pulses stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Access width code (0 byte, 1 half-word, 2 word) |
| bus_addr | input | 8 | Byte offset into the port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the request cycle |
| bus_fault | output | 2 | 0 ok, 1 wrong width, 2 unmapped |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Pin output enables |
| out_chg | output | 16 | One-cycle strobe per output pin whose value changed |
| irq_a | output | 1 | Interrupt line through mask A |
| irq_b | output | 1 | Interrupt line through mask B |

## Verification
The assertions take for granted that bus_req is never left high across a reset and that pin_in may change on any cycle, including every cycle. The edge-pulse property therefore holds only while polarity, edge select, both-edges and enable stay unchanged for two cycles. The bench drives every input one time unit after the rising edge and holds it for a whole cycle, so all sampling is clean. Random phases mix configuration writes with arbitrary pin activity, which includes back-to-back transitions that the edge property has to tolerate.

// File: rtl/pio_pkg.sv
// Shared constants for the GPIO port: register indices, the legal size
// code and fault codes. Assumes four bytes between register indices.
package pio_pkg;
    localparam logic [1:0] SIZE_HALF = 2'd1;

    localparam int IX_DATA  = 0;
    localparam int IX_MASKA = 4;
    localparam int IX_MASKB = 8;
    localparam int IX_DIR   = 12;
    localparam int IX_POL   = 13;
    localparam int IX_EDGE  = 14;
    localparam int IX_BOTH  = 15;
    localparam int IX_INEN  = 16;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_WIDTH    = 2'd1,
        FLT_UNMAPPED = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLR   = 2'd1,
        OP_SET   = 2'd2,
        OP_TGL   = 2'd3
    } alias_e;
endpackage

// File: rtl/pio_regfile.sv
// Register file and bus decoder. Holds data, direction, both masks and
// the pin configuration; forms the fault code and read data in the
// request cycle; raises the output-change strobe one cycle after a write.
// Assumes bus_req lasts one cycle per access.
module pio_regfile
    import pio_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_wr,
    input  logic [1:0]      bus_size,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    output logic [1:0]      bus_fault,
    output logic [NPIN-1:0] data_q,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] mska_q,
    output logic [NPIN-1:0] mskb_q,
    output logic [NPIN-1:0] pol_q,
    output logic [NPIN-1:0] edge_q,
    output logic [NPIN-1:0] both_q,
    output logic [NPIN-1:0] inen_q,
    output logic [NPIN-1:0] chg_q
);
    localparam int IW = AW - 2;

    logic [IW-1:0]   idx;
    int              idx_i;
    fault_e          fault;
    logic            wr_go, rd_go, touch_out;
    logic [NPIN-1:0] data_n, dir_n, mska_n, mskb_n, pol_n, edge_n, both_n, inen_n;

    assign idx   = bus_addr[AW-1:2];
    assign idx_i = int'(idx);

    function automatic logic [NPIN-1:0] apply_op(input logic [NPIN-1:0] cur,
                                                 input logic [1:0] op,
                                                 input logic [NPIN-1:0] w);
        case (alias_e'(op))
            OP_CLR:  return cur & ~w;
            OP_SET:  return cur | w;
            OP_TGL:  return cur ^ w;
            default: return w;
        endcase
    endfunction

    // Classify the access: width is checked before the address.
    always_comb begin
        fault = FLT_NONE;
        if (bus_req) begin
            if (bus_size != SIZE_HALF)
                fault = FLT_WIDTH;
            else if (bus_addr[1:0] != 2'b00 || idx_i > IX_INEN)
                fault = FLT_UNMAPPED;
        end
    end

    assign bus_fault = fault;
    assign wr_go     = bus_req &&  bus_wr && fault == FLT_NONE;
    assign rd_go     = bus_req && !bus_wr && fault == FLT_NONE;
    assign touch_out = wr_go && (idx_i < IX_MASKA || idx_i == IX_DIR);

    // Next register values for a legal write.
    always_comb begin
        data_n = data_q; dir_n = dir_q; mska_n = mska_q; mskb_n = mskb_q;
        pol_n  = pol_q;  edge_n = edge_q; both_n = both_q; inen_n = inen_q;
        if (wr_go) begin
            if (idx_i < IX_DIR) begin
                case (idx[3:2])
                    2'd0:    data_n = apply_op(data_q, idx[1:0], bus_wdata);
                    2'd1:    mska_n = apply_op(mska_q, idx[1:0], bus_wdata);
                    default: mskb_n = apply_op(mskb_q, idx[1:0], bus_wdata);
                endcase
            end else begin
                case (idx_i)
                    IX_DIR:  dir_n  = bus_wdata;
                    IX_POL:  pol_n  = bus_wdata;
                    IX_EDGE: edge_n = bus_wdata;
                    IX_BOTH: both_n = bus_wdata;
                    default: inen_n = bus_wdata;
                endcase
            end
        end
    end

    // Read mux: companions read back their base register.
    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            if (idx_i < IX_DIR) begin
                case (idx[3:2])
                    2'd0:    bus_rdata = data_q;
                    2'd1:    bus_rdata = mska_q;
                    default: bus_rdata = mskb_q;
                endcase
            end else begin
                case (idx_i)
                    IX_DIR:  bus_rdata = dir_q;
                    IX_POL:  bus_rdata = pol_q;
                    IX_EDGE: bus_rdata = edge_q;
                    IX_BOTH: bus_rdata = both_q;
                    default: bus_rdata = inen_q;
                endcase
            end
        end
    end

    // Register update and output-change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0; dir_q <= '0; mska_q <= '0; mskb_q <= '0;
            pol_q  <= '0; edge_q <= '0; both_q <= '0; inen_q <= '0;
            chg_q  <= '0;
        end else begin
            data_q <= data_n; dir_q <= dir_n; mska_q <= mska_n; mskb_q <= mskb_n;
            pol_q  <= pol_n;  edge_q <= edge_n; both_q <= both_n; inen_q <= inen_n;
            chg_q  <= touch_out ? (dir_n & (data_n ^ data_q)) : '0;
        end
    end

    AST_FAULT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_fault != FLT_NONE) |=> ($stable(data_q) && $stable(dir_q) &&
        $stable(mska_q) && $stable(mskb_q) && $stable(pol_q) && $stable(edge_q) &&
        $stable(both_q) && $stable(inen_q))); // R4 R5
    AST_CHG_OUTPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_q & ~dir_q) == '0); // R7
    AST_CHG_REAL_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_q & ~(data_q ^ $past(data_q))) == '0); // R7
    AST_FAULT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fault != FLT_NONE) |-> bus_rdata == '0); // R4
endmodule

// File: rtl/pio_irq.sv
// Pin input path and interrupt generation. Each pin passes through two
// synchronising flops, then edge detection against the previous synced
// value. Per-pin configuration sets its interrupt-state bit, and the two
// masks reduce the state vector to two lines. Assumes pin_in is asynchronous.
module pio_irq #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] pol,
    input  logic [NPIN-1:0] edge_md,
    input  logic [NPIN-1:0] both,
    input  logic [NPIN-1:0] inen,
    input  logic [NPIN-1:0] mska,
    input  logic [NPIN-1:0] mskb,
    output logic            irq_a,
    output logic            irq_b
);
    logic [NPIN-1:0] s1, s2, prev, st, st_n;

    // Per-pin qualification and next interrupt state.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic rise, fall, hit;
        assign rise = s2[i] & ~prev[i];
        assign fall = ~s2[i] & prev[i];
        assign hit  = both[i] ? (rise | fall) : (pol[i] ? fall : rise);
        assign st_n[i] = !inen[i] ? (edge_md[i] ? 1'b0 : st[i])
                                  : (edge_md[i] ? hit : (s2[i] ^ pol[i]));
    end

    // Synchroniser, edge history and interrupt-state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0; s2 <= '0; prev <= '0; st <= '0;
        end else begin
            s1 <= pin_in; s2 <= s1; prev <= s2; st <= st_n;
        end
    end

    assign irq_a = |(st & mska);
    assign irq_b = |(st & mskb);

    AST_MASKA_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mska == '0) |-> !irq_a); // R8
    AST_MASKB_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mskb == '0) |-> !irq_b); // R8
    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_md) == $past(edge_md, 2) && $past(pol) == $past(pol, 2) &&
         $past(both) == '0 && $past(both, 2) == '0 && $past(inen) == $past(inen, 2))
        |-> (st & $past(st) & $past(edge_md)) == '0); // R10
    AST_DISABLED_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st ^ $past(st)) & ~$past(inen) & ~$past(edge_md)) == '0); // R12
endmodule

// File: rtl/pio_port16.sv
// Top of the GPIO port: joins the register file and the interrupt path,
// and drives the pins straight from the data and direction registers.
module pio_port16 #(
    parameter int NPIN = 16,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_wr,
    input  logic [1:0]      bus_size,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    output logic [1:0]      bus_fault,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] out_chg,
    output logic            irq_a,
    output logic            irq_b
);
    logic [NPIN-1:0] data_q, dir_q, mska_q, mskb_q, pol_q, edge_q, both_q, inen_q, chg_q;

    pio_regfile #(.NPIN(NPIN), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_fault(bus_fault),
        .data_q(data_q), .dir_q(dir_q), .mska_q(mska_q), .mskb_q(mskb_q),
        .pol_q(pol_q), .edge_q(edge_q), .both_q(both_q), .inen_q(inen_q),
        .chg_q(chg_q)
    );

    pio_irq #(.NPIN(NPIN)) u_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pol(pol_q), .edge_md(edge_q), .both(both_q), .inen(inen_q),
        .mska(mska_q), .mskb(mskb_q),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
    assign out_chg = chg_q;

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_chg & ~pin_oe) == '0); // R7
    AST_CHG_PINS_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_chg & ~(pin_out ^ $past(pin_out))) == '0); // R6
endmodule

// File: tb/pio_port16_bench.sv
`timescale 1ns/1ps
module pio_port16_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, pin_in = '0;
    logic [15:0] bus_rdata, pin_out, pin_oe, out_chg;
    logic [1:0]  bus_fault;
    logic        irq_a, irq_b;

    int    checks = 0, errors = 0;
    bit    chk_en = 1'b0, done = 1'b0;
    string bus_tag = "R2", irq_tag = "R8";

    always #2.5 clk = ~clk;

    pio_port16 u_pio_port16 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_fault(bus_fault), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .out_chg(out_chg),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    // Behavioural reference state.
    logic [15:0] m_reg [0:16];   // indexed by base register index; companions unused
    logic [15:0] m_chg = '0, m_st = '0;
    logic [15:0] hist [$] = '{16'h0, 16'h0, 16'h0};

    function automatic logic [1:0] exp_fault();
        if (!bus_req) return 2'd0;
        if (bus_size != 2'd1) return 2'd1;
        if (bus_addr[1:0] != 2'b00 || bus_addr[7:2] > 6'd16) return 2'd2;
        return 2'd0;
    endfunction

    function automatic int base_of(input int ix);
        if (ix < 12) return ix - (ix % 4);
        return ix;
    endfunction

    function automatic logic [15:0] exp_rdata();
        if (!bus_req || bus_wr || exp_fault() != 2'd0) return 16'h0;
        return m_reg[base_of(int'(bus_addr[7:2]))];
    endfunction

    // Reference update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k <= 16; k++) m_reg[k] = '0;
            m_chg = '0; m_st = '0;
            hist = '{16'h0, 16'h0, 16'h0};
        end else begin
            logic [15:0] nst, cur, prv, olddata;
            int ix, b;
            cur = hist[1]; prv = hist[2];
            for (int i = 0; i < 16; i++) begin
                bit r, f, q;
                r = cur[i] && !prv[i];
                f = !cur[i] && prv[i];
                q = m_reg[15][i] ? (r || f) : (m_reg[13][i] ? f : r);
                if (!m_reg[16][i]) nst[i] = m_reg[14][i] ? 1'b0 : m_st[i];
                else if (m_reg[14][i]) nst[i] = q;
                else nst[i] = cur[i] ^ m_reg[13][i];
            end
            m_st = nst;
            m_chg = '0;
            if (bus_req && bus_wr && exp_fault() == 2'd0) begin
                ix = int'(bus_addr[7:2]);
                b = base_of(ix);
                olddata = m_reg[0];
                case (ix - b)
                    1: m_reg[b] = m_reg[b] & ~bus_wdata;
                    2: m_reg[b] = m_reg[b] | bus_wdata;
                    3: m_reg[b] = m_reg[b] ^ bus_wdata;
                    default: m_reg[b] = bus_wdata;
                endcase
                if (b == 0 || b == 12) m_chg = m_reg[12] & (m_reg[0] ^ olddata);
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    task automatic cmp(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare against the reference on every falling edge.
    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            cmp("R6", "pin_out", pin_out, m_reg[0]);
            cmp("R6", "pin_oe", pin_oe, m_reg[12]);
            cmp("R7", "out_chg", out_chg, m_chg);
            cmp(irq_tag, "irq_a", {15'h0, irq_a}, {15'h0, |(m_st & m_reg[4])});
            cmp(irq_tag, "irq_b", {15'h0, irq_b}, {15'h0, |(m_st & m_reg[8])});
            if (bus_req) begin
                cmp(bus_tag, "bus_fault", {14'h0, bus_fault}, {14'h0, exp_fault()});
                cmp(bus_tag, "bus_rdata", bus_rdata, exp_rdata());
            end
        end
    end

    task automatic acc(input logic w, input logic [7:0] a, input logic [1:0] sz,
                       input logic [15:0] v);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_wr = w; bus_addr = a; bus_size = sz; bus_wdata = v;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wreg(input int ix, input logic [15:0] v);
        acc(1'b1, 8'(ix * 4), 2'd1, v);
    endtask

    task automatic rreg(input int ix);
        acc(1'b0, 8'(ix * 4), 2'd1, 16'h0);
    endtask

    task automatic pins(input logic [15:0] v, input int hold);
        @(posedge clk); #1;
        pin_in = v;
        repeat (hold) @(posedge clk);
    endtask

    initial begin
        repeat (3) begin
            @(posedge clk); #1; chk_en = 1'b1;
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen at the ports
        cmp("R1", "reset pins", pin_out | pin_oe | out_chg, 16'h0);
        cmp("R1", "reset irq", {14'h0, irq_a, irq_b}, 16'h0);

        bus_tag = "R2";
        for (int k = 0; k <= 16; k++) rreg(k);
        wreg(0, 16'h00F0); wreg(12, 16'hA5A5); wreg(13, 16'h1234);
        rreg(0); rreg(12); rreg(13);

        bus_tag = "R3";
        wreg(2, 16'h000F); rreg(3);
        wreg(1, 16'h00F0); rreg(1);
        wreg(3, 16'h0011); rreg(2);
        wreg(6, 16'h8001); wreg(7, 16'h0003); wreg(5, 16'h8000); rreg(5);
        wreg(10, 16'h00FF); wreg(9, 16'h000F); wreg(11, 16'h0101); rreg(11);
        wreg(12, 16'hFF00); wreg(0, 16'h0F0F); wreg(3, 16'hFFFF); wreg(12, 16'h00FF);

        bus_tag = "R4";
        acc(1'b1, 8'h00, 2'd0, 16'hFFFF); acc(1'b1, 8'h00, 2'd2, 16'h1111);
        acc(1'b1, 8'h02, 2'd0, 16'h2222); acc(1'b0, 8'hFC, 2'd3, 16'h0);
        rreg(0);

        bus_tag = "R5";
        acc(1'b1, 8'h02, 2'd1, 16'hFFFF); acc(1'b1, 8'd68, 2'd1, 16'hFFFF);
        acc(1'b0, 8'hFC, 2'd1, 16'h0); acc(1'b0, 8'h41, 2'd1, 16'h0);
        rreg(0);

        // Clean interrupt setup.
        bus_tag = "R8";
        wreg(4, 16'h0000); wreg(8, 16'h0000); wreg(13, 16'h0000);
        wreg(14, 16'h0000); wreg(15, 16'h0000); wreg(16, 16'h0000);
        pins(16'h0000, 4);

        irq_tag = "R9";
        wreg(16, 16'h0003); wreg(4, 16'h0001); wreg(8, 16'h0002);
        pins(16'h0001, 6); pins(16'h0003, 6); pins(16'h0000, 6);
        wreg(13, 16'h0002); pins(16'h0000, 6); pins(16'h0002, 6);

        irq_tag = "R8";
        wreg(13, 16'h0000); pins(16'h0001, 6);
        wreg(5, 16'h0001); wreg(6, 16'h0001); wreg(7, 16'h0001);
        wreg(10, 16'h0001); wreg(9, 16'h0001);

        irq_tag = "R10";
        wreg(14, 16'h0004); wreg(16, 16'h0004); wreg(4, 16'h0004);
        pins(16'h0000, 6); pins(16'h0004, 6); pins(16'h0000, 6);
        wreg(13, 16'h0004); pins(16'h0004, 6); pins(16'h0000, 6);

        irq_tag = "R11";
        wreg(15, 16'h0004);
        pins(16'h0004, 6); pins(16'h0000, 6); pins(16'h0004, 1); pins(16'h0000, 6);

        irq_tag = "R12";
        wreg(16, 16'h0001); wreg(4, 16'h0001); wreg(13, 16'h0000); wreg(14, 16'h0000);
        pins(16'h0001, 6); wreg(16, 16'h0000);
        pins(16'h0000, 6); wreg(14, 16'h0004); wreg(4, 16'h0005);
        pins(16'h0004, 6); pins(16'h0000, 6);

        // Mixed random phase.
        bus_tag = "R3"; irq_tag = "R8";
        for (int n = 0; n < 600; n++) begin
            @(posedge clk); #1;
            pin_in = 16'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                bus_req = 1'b1; bus_wr = 1'($urandom); bus_wdata = 16'($urandom);
                bus_addr = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 16) * 4);
                bus_size = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'd1;
            end else begin
                bus_req = 1'b0;
            end
        end
        @(posedge clk); #1; bus_req = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule